// File: doc/BRIEF.md
# Event Interrupter Register Set with Moderation

This block holds the software-visible registers of one event interrupter. It sits on a simple 32-bit register bus with a write strobe and a combinational read. It keeps a 64-bit event-ring dequeue pointer, an event-handler-busy flag and an interrupt moderation register. An event source outside the block raises `evt_pending` while it has events for software. The block turns that level into a one-cycle interrupt pulse. The busy flag and a moderation down-counter keep it from interrupting again before software has handled the last batch and the quiet interval has passed.

The pointer is written as two 32-bit halves, low half first. The low half is only staged. The pointer changes when the high half is written. When `ADDR64` is 0 the block models a part with 32-bit addressing only: the high-half write is dropped, and a low-half write commits at once with the upper word held at zero. The busy flag sits in bit 3 of the low pointer word and is cleared by writing one to it. Bits 2:0 of that word are kept with the pointer. The moderation register holds the interval in bits 15:0 and the live down-counter in bits 31:16. The counter steps once per `tick` pulse.

Top module: `ir_interrupter`

## Requirements
- R1: After reset the committed pointer is zero, the busy flag is clear, the interval is 0x4000, the counter is zero and `irq` is low.
- R2: With `ADDR64`=1, a write to offset 1 (pointer low) does not change `deq_ptr`. A later offset-1 write replaces the staged value.
- R3: With `ADDR64`=1, a write to offset 2 (pointer high) sets `deq_ptr` to {written word, staged low word}. Bits 2:0 of the staged word are kept, and bit 3 is always committed as 0.
- R4: With `ADDR64`=0, a write to offset 2 is ignored and reads back as 0. A write to offset 1 sets `deq_ptr` to {32'h0, written word with bit 3 forced to 0} on the next edge.
- R5: The busy flag is bit 3 of offset 1. A write to offset 1 with bit 3 = 0 leaves it unchanged, and one with bit 3 = 1 clears it.
- R6: When `evt_pending` is high, the counter is zero and busy is clear on an edge, `irq` is high for exactly the following cycle and busy is set on the same edge.
- R7: On the edge that raises `irq` the counter is loaded with the interval. It then decreases by one on each edge with `tick` high, down to zero. No interrupt is raised while it is non-zero, even when busy has been cleared.
- R8: Offset 0 reads {counter, interval}. A write to offset 0 sets the interval from bits 15:0 and the counter from bits 31:16.
- R9: A read of offset 1 returns {committed pointer bits 31:4, busy, committed bits 2:0}. A read of offset 2 returns committed bits 63:32. Reads show committed values, never the staged low word.
- R10: Offset 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pending | input | 1 | Events are waiting for software |
| tick | input | 1 | Moderation time-base pulse |
| deq_ptr | output | 64 | Committed dequeue pointer, bit 3 zero |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker treats `evt_pending`, `tick` and the bus as synchronous inputs. It assumes a write lasts one cycle and that `reg_addr` is always one of the four offsets. It takes no pairing of low and high writes for granted. It checks instead that the pointer moves only on the committing write, whatever came before. The stimulus changes inputs only on falling edges and pulses `reg_wr` and `tick` for single cycles. It keeps `evt_pending` high across the busy and moderation windows, so that the gating, rather than a missing request, is what holds `irq` low.

// File: rtl/ir_pkg.sv
package ir_pkg;

    localparam int WORD_W  = 32;
    localparam int PTR_W   = 2 * WORD_W;
    localparam int ADDR_W  = 2;
    localparam int BUSY_POS = 3;

    localparam logic [ADDR_W-1:0] OFS_MOD    = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_PTR_LO = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_PTR_HI = 2'd2;

    typedef enum logic [1:0] {
        SEL_MOD,
        SEL_PTR_LO,
        SEL_PTR_HI,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } ptr_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_MOD:    return SEL_MOD;
            OFS_PTR_LO: return SEL_PTR_LO;
            OFS_PTR_HI: return SEL_PTR_HI;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] strip_busy(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[BUSY_POS] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ir_ptr_stage.sv
module ir_ptr_stage
    import ir_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output ptr_t              ptr
);

    logic [WORD_W-1:0] stage_q;
    ptr_t              ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (wr_lo) begin
            stage_q <= strip_busy(wdata);
        end
    end

    generate
        if (ADDR64) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q <= '0;
                end else if (wr_hi) begin
                    ptr_q.hi <= wdata;
                    ptr_q.lo <= stage_q;
                end
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q <= '0;
                end else if (wr_lo) begin
                    ptr_q.hi <= '0;
                    ptr_q.lo <= strip_busy(wdata);
                end
            end
        end
    endgenerate

    assign ptr = ptr_q;

endmodule

// File: rtl/ir_moderation.sv
module ir_moderation
    import ir_pkg::*;
#(
    parameter int          IVL_W     = 16,
    parameter logic [15:0] RESET_IVL = 16'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick,
    input  logic              load,
    output logic [IVL_W-1:0]  interval,
    output logic [IVL_W-1:0]  count,
    output logic              cnt_zero
);

    localparam int CNT_LSB = IVL_W;
    localparam int CNT_MSB = 2 * IVL_W - 1;

    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= IVL_W'(RESET_IVL);
        end else if (wr) begin
            ivl_q <= wdata[IVL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ivl_q;
        end else if (wr) begin
            cnt_q <= wdata[CNT_MSB:CNT_LSB];
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign interval = ivl_q;
    assign count    = cnt_q;
    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/ir_event_gate.sv
module ir_event_gate (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic cnt_zero,
    input  logic clr_req,
    output logic fire,
    output logic busy,
    output logic irq
);

    logic busy_q;
    logic irq_q;

    assign fire = evt && cnt_zero && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= fire;
            if (fire) begin
                busy_q <= 1'b1;
            end else if (clr_req) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign irq  = irq_q;

endmodule

// File: rtl/ir_interrupter.sv
module ir_interrupter
    import ir_pkg::*;
#(
    parameter bit          ADDR64    = 1'b1,
    parameter int          IVL_W     = 16,
    parameter logic [15:0] RESET_IVL = 16'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              evt_pending,
    input  logic              tick,
    output logic [PTR_W-1:0]  deq_ptr,
    output logic              irq
);

    reg_sel_e         sel;
    logic             wr_mod, wr_lo, wr_hi;
    ptr_t             ptr;
    logic [IVL_W-1:0] ivl_q, cnt_q;
    logic             cnt_zero, fire, busy_q;

    assign sel    = decode_ofs(reg_addr);
    assign wr_mod = reg_wr && (sel == SEL_MOD);
    assign wr_lo  = reg_wr && (sel == SEL_PTR_LO);
    assign wr_hi  = reg_wr && (sel == SEL_PTR_HI);

    ir_ptr_stage #(.ADDR64(ADDR64)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .ptr   (ptr)
    );

    ir_moderation #(.IVL_W(IVL_W), .RESET_IVL(RESET_IVL)) u_mod (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_mod),
        .wdata    (reg_wdata),
        .tick     (tick),
        .load     (fire),
        .interval (ivl_q),
        .count    (cnt_q),
        .cnt_zero (cnt_zero)
    );

    ir_event_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pending),
        .cnt_zero (cnt_zero),
        .clr_req  (wr_lo && reg_wdata[BUSY_POS]),
        .fire     (fire),
        .busy     (busy_q),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_MOD: begin
                reg_rdata = {cnt_q, ivl_q};
            end
            SEL_PTR_LO: begin
                reg_rdata = ptr.lo;
                reg_rdata[BUSY_POS] = busy_q;
            end
            SEL_PTR_HI: begin
                reg_rdata = ptr.hi;
            end
            default: begin
                reg_rdata = '0;
            end
        endcase
    end

    assign deq_ptr = ptr;

endmodule

// File: rtl/ir_checker.sv
module ir_checker
    import ir_pkg::*;
#(
    parameter bit ADDR64 = 1'b1,
    parameter int IVL_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              evt_pending,
    input logic [PTR_W-1:0]  deq_ptr,
    input logic              irq,
    input logic              busy,
    input logic [IVL_W-1:0]  cnt,
    input logic [IVL_W-1:0]  ivl
);

    logic commit_wr;
    assign commit_wr = reg_wr && (reg_addr == (ADDR64 ? OFS_PTR_HI : OFS_PTR_LO));

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_wr |=> $stable(deq_ptr)) else $error("pointer moved without commit"); // R2

    AST_BIT3_ZERO: assert property (@(posedge clk) disable iff (rst)
        deq_ptr[BUSY_POS] == 1'b0) else $error("busy bit leaked into pointer"); // R3

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ADDR64 |-> deq_ptr[PTR_W-1:WORD_W] == '0) else $error("upper word set on 32-bit part"); // R4

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq longer than one cycle"); // R6

    AST_IRQ_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq |-> busy) else $error("irq without busy"); // R6

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_pending) && !$past(busy)) else $error("irq without request"); // R6

    AST_CNT_LOADED: assert property (@(posedge clk) disable iff (rst)
        irq |-> cnt == $past(ivl)) else $error("counter not loaded"); // R7

    AST_CNT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> !irq) else $error("irq while counting"); // R7

endmodule

bind ir_interrupter ir_checker #(.ADDR64(ADDR64), .IVL_W(IVL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .evt_pending (evt_pending),
    .deq_ptr     (deq_ptr),
    .irq         (irq),
    .busy        (busy_q),
    .cnt         (cnt_q),
    .ivl         (ivl_q)
);

// File: tb/ir_interrupter_tb.sv
module ir_interrupter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        evt_pending = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] rdata, rdata32;
    logic [63:0] ptr, ptr32;
    logic        irq, irq32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ir_interrupter u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .evt_pending(evt_pending),
        .tick(tick), .deq_ptr(ptr), .irq(irq)
    );

    ir_interrupter #(.ADDR64(1'b0)) u_dut32 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata32), .evt_pending(evt_pending),
        .tick(tick), .deq_ptr(ptr32), .irq(irq32)
    );

    // kind: 0 write, 1 read compare, 2 deq_ptr low word, 3 deq_ptr high word
    localparam int NV = 19;
    localparam logic [67:0] VEC [NV] = '{
        {2'd1, 2'd0, 32'h0,         32'h0000_4000}, // R1 R8
        {2'd1, 2'd1, 32'h0,         32'h0000_0000}, // R1
        {2'd0, 2'd1, 32'hAAAA_5555, 32'h0},
        {2'd2, 2'd0, 32'h0,         32'h0000_0000}, // R2
        {2'd3, 2'd0, 32'h0,         32'h0000_0000}, // R2
        {2'd1, 2'd1, 32'h0,         32'h0000_0000}, // R9
        {2'd0, 2'd2, 32'h1234_5678, 32'h0},
        {2'd2, 2'd0, 32'h0,         32'hAAAA_5555}, // R3
        {2'd3, 2'd0, 32'h0,         32'h1234_5678}, // R3
        {2'd1, 2'd2, 32'h0,         32'h1234_5678}, // R9
        {2'd0, 2'd1, 32'h0000_0107, 32'h0},
        {2'd2, 2'd0, 32'h0,         32'hAAAA_5555}, // R2
        {2'd1, 2'd1, 32'h0,         32'hAAAA_5555}, // R9
        {2'd0, 2'd0, 32'h0003_0010, 32'h0},
        {2'd1, 2'd0, 32'h0,         32'h0003_0010}, // R8
        {2'd0, 2'd3, 32'hFFFF_FFFF, 32'h0},
        {2'd1, 2'd3, 32'h0,         32'h0000_0000}, // R10
        {2'd1, 2'd0, 32'h0,         32'h0003_0010}, // R10
        {2'd3, 2'd0, 32'h0,         32'h1234_5678}  // R10
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 ptr", ptr, 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [1:0]  a;
            logic [31:0] d, e;
            {k, a, d, e} = VEC[i];
            case (k)
                2'd0: wr(a, d);
                2'd1: rd_chk($sformatf("R8/R9/R10 vec%0d", i), a, e);
                2'd2: chk($sformatf("R2/R3 vec%0d lo", i), ptr[31:0], e);
                default: chk($sformatf("R2/R3 vec%0d hi", i), ptr[63:32], e);
            endcase
        end

        // R6: interrupt pulse and busy set
        wr(2'd0, 32'h0000_0002);
        @(negedge clk);
        evt_pending = 1'b1;
        @(negedge clk);
        #1;
        chk("R6 irq high", irq, 1);
        rd_chk("R6 busy set", 2'd1, 32'hAAAA_555D);
        rd_chk("R7 counter loaded", 2'd0, 32'h0002_0002);
        @(negedge clk);
        #1;
        chk("R6 irq one cycle", irq, 0);

        // R5: write zero keeps busy, write one clears it
        wr(2'd1, 32'h0000_0000);
        rd_chk("R5 zero keeps busy", 2'd1, 32'hAAAA_555D);
        wr(2'd1, 32'h0000_0008);
        rd_chk("R5 one clears busy", 2'd1, 32'hAAAA_5555);
        chk("R7 blocked by counter", irq, 0);

        // R7: tick countdown
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        rd_chk("R7 count 1", 2'd0, 32'h0001_0002);
        chk("R7 no irq at 1", irq, 0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        rd_chk("R7 count 0", 2'd0, 32'h0000_0002);
        chk("R7 no irq on reaching 0", irq, 0);
        @(negedge clk);
        #1;
        chk("R7 irq after expiry", irq, 1);
        evt_pending = 1'b0;

        // R4: 32-bit-only addressing
        wr(2'd1, 32'h1111_2229);
        chk("R4 low commits", ptr32, 64'h0000_0000_1111_2221);
        wr(2'd2, 32'hFFFF_0000);
        chk("R4 high ignored", ptr32, 64'h0000_0000_1111_2221);
        reg_addr = 2'd2;
        #1;
        chk("R4 high reads zero", rdata32, 0);

        done = 1'b1;
        summary();
    end

endmodule